// File: doc/BRIEF.md
# Flash Window Base-Address Decoder

This block owns the configuration register for an on-chip flash array and decides, on every bus access, whether that access reaches the flash. A core access that falls in a relocatable 512 KB window hits directly, provided the window is enabled and the access type is not masked. A second alias window, placed at a fixed offset above a relocatable peripheral base, serves the other bus masters and core writes during programming. A read through that window costs two extra cycles.

The decoder works only on the upper address bits (the 512 KB page number), since both windows are page-aligned. Each access presented with `acc_valid` produces a registered one-cycle select (none, direct or alias), an error flag for blocked writes and a delayed `acc_ready` pulse. The enable bit of the register takes its reset value from the boot-configuration pins and from a security flag that forces it on.

Top module: `flash_window_decoder`

## Requirements
- R1: A core access whose address bits [31:19] (`acc_page`) equal register bits [31:19] selects the direct window (`sel_direct`) when the enable bit is 1, the matching mask bit is 0 and the access is not a blocked write.
- R2: The register keeps bits [31:19] (page), 8 (write protect), 6 (cache-inhibit hint), 5 to 2 (masks for supervisor code, supervisor data, user code and user data, in that order) and 0 (enable). All other bits read as 0, and writing them has no effect (mask 0xFFF8017D).
- R3: At reset the page is 0, write protect is 1, the cache-inhibit hint and all four masks are 0.
- R4: At reset, enable is 1 if `boot_cfg_en` is 1 and `boot_mode` = 3'b110. It is also 1 if `boot_cfg_en` is 1, `boot_mode` = 3'b111 and `boot_sel` = 2'b00. Otherwise it is 0. `boot_mode` is {D26, D17, D16} and `boot_sel` is {D19, D18}.
- R5: When `flash_secured` is 1 at reset, enable resets to 1 whatever the boot pins say.
- R6: The direct window is never selected when enable is 0, when `acc_core` is 0, or when the mask bit picked by {`acc_super`,`acc_code`} is 1.
- R7: An access from any master whose page equals `periph_page` + 0x080 (the peripheral base plus 0x0400_0000) selects the alias window (`sel_backdoor`), regardless of enable and the masks. With the base at 0x4000_0000 the alias starts at 0x4400_0000. When both windows qualify, the direct window wins.
- R8: A write that qualifies for either window while write protect is 1 selects nothing and raises `acc_err` for one cycle.
- R9: Exactly one of `sel_none`, `sel_direct` and `sel_backdoor` is 1 in every cycle. The select reflects the access sampled at the previous edge, and is `sel_none` if no access was presented.
- R10: `acc_ready` pulses BASE_LAT cycles after the select for direct accesses and alias writes, and BASE_LAT+2 cycles after it for alias reads. It does not pulse for misses or errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; boot pins sampled while low |
| boot_cfg_en | input | 1 | Reset-configuration override asserted |
| boot_mode | input | 3 | Boot mode pins {D26, D17, D16} |
| boot_sel | input | 2 | Boot select pins {D19, D18} |
| flash_secured | input | 1 | Flash configuration field reports a secured part |
| reg_wr_en | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| periph_page | input | 13 | Bits [31:19] of the relocatable peripheral base |
| acc_valid | input | 1 | Access presented this cycle |
| acc_page | input | 13 | Bits [31:19] of the access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_code | input | 1 | 1 = instruction fetch, 0 = data |
| acc_core | input | 1 | 1 = access from the core, 0 = other master |
| sel_none | output | 1 | No flash select this cycle |
| sel_direct | output | 1 | Flash selected through the direct window |
| sel_backdoor | output | 1 | Flash selected through the alias window |
| acc_err | output | 1 | Write blocked by write protect |
| acc_ready | output | 1 | Access completion pulse |

## Verification
Every reset-pin combination is swept, including both boot modes that enable the flash and a secured part with enable-off pins. A wrong decode would leave the flash unreachable at boot, or reachable when it must not be. Overlapping windows check that the direct path wins, and non-core masters aimed at the direct page check that they miss. Each mask bit is exercised against its own access type, so a swapped mask index shows up as a wrong select. Alias reads and writes are timed separately, so a latency applied to the wrong access kind moves the ready pulse by two cycles and is caught.

// File: rtl/flash_win_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the flash window decoder.
// Assumes a 32-bit address space and a power-of-two window size.
package flash_win_pkg;
    localparam int FW_AW       = 32;
    localparam int FW_WIN_LOG2 = 19;
    localparam int FW_PG_W     = FW_AW - FW_WIN_LOG2;

    // Bit positions in the configuration register.
    localparam int FW_B_WP   = 8;
    localparam int FW_B_CI   = 6;
    localparam int FW_B_MSK  = 2;   // masks occupy FW_B_MSK+3 .. FW_B_MSK
    localparam int FW_B_V    = 0;

    // Fields the decoder needs from the register.
    typedef struct packed {
        logic [FW_PG_W-1:0] page;
        logic               wprot;
        logic [3:0]         amask;  // index {super, code}
        logic               valid;
    } fw_dec_t;
endpackage

// File: rtl/fwin_cfg_reg.sv
`timescale 1ns/1ps
// Configuration register for the flash window.
// Holds page, write protect, cache-inhibit hint, access masks and enable.
// Assumes boot pins are stable while rst_n is low (sampled on reset edges).
module fwin_cfg_reg
    import flash_win_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_cfg_en,
    input  logic [2:0]           boot_mode,
    input  logic [1:0]           boot_sel,
    input  logic                 flash_secured,
    input  logic                 wr_en,
    input  logic [FW_AW-1:0]     wdata,
    output fw_dec_t              dec,
    output logic [FW_AW-1:0]     rdata
);
    fw_dec_t cfg_q;
    logic    cinh_q;
    logic    valid_rst;

    // Enable value at reset: boot-mode decode, overridden by security.
    always_comb begin
        valid_rst = flash_secured
                  | (boot_cfg_en & (boot_mode == 3'b110))
                  | (boot_cfg_en & (boot_mode == 3'b111) & (boot_sel == 2'b00));
    end

    // Register state: reset from pins, else load writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.page  <= '0;
            cfg_q.wprot <= 1'b1;
            cfg_q.amask <= '0;
            cfg_q.valid <= valid_rst;
            cinh_q      <= 1'b0;
        end else if (wr_en) begin
            cfg_q.page  <= wdata[FW_AW-1:FW_WIN_LOG2];
            cfg_q.wprot <= wdata[FW_B_WP];
            cfg_q.amask <= wdata[FW_B_MSK+3:FW_B_MSK];
            cfg_q.valid <= wdata[FW_B_V];
            cinh_q      <= wdata[FW_B_CI];
        end
    end

    // Read-back image with reserved bits held at zero.
    always_comb begin
        rdata                          = '0;
        rdata[FW_AW-1:FW_WIN_LOG2]     = cfg_q.page;
        rdata[FW_B_WP]                 = cfg_q.wprot;
        rdata[FW_B_CI]                 = cinh_q;
        rdata[FW_B_MSK+3:FW_B_MSK]     = cfg_q.amask;
        rdata[FW_B_V]                  = cfg_q.valid;
    end

    assign dec = cfg_q;
endmodule

// File: rtl/fwin_match.sv
`timescale 1ns/1ps
// Combinational window decode for one access.
// Assumes the peripheral base and both windows are page-aligned.
// Direct window has priority when both windows match.
module fwin_match
    import flash_win_pkg::*;
#(
    parameter logic [FW_PG_W-1:0] BD_PG = 13'h080
) (
    input  fw_dec_t              dec,
    input  logic                 acc_valid,
    input  logic [FW_PG_W-1:0]   acc_page,
    input  logic [FW_PG_W-1:0]   periph_page,
    input  logic                 acc_write,
    input  logic                 acc_super,
    input  logic                 acc_code,
    input  logic                 acc_core,
    output logic                 hit_dir,
    output logic                 hit_bd,
    output logic                 wp_err
);
    logic [FW_PG_W-1:0] bd_page;
    logic               dir_ok;
    logic               bd_ok;
    logic               masked;

    // Qualify both windows, then resolve protection and priority.
    always_comb begin
        bd_page = periph_page + BD_PG;
        masked  = dec.amask[{acc_super, acc_code}];
        dir_ok  = acc_valid & acc_core & dec.valid & ~masked
                & (acc_page == dec.page);
        bd_ok   = acc_valid & (acc_page == bd_page);
        wp_err  = (dir_ok | bd_ok) & acc_write & dec.wprot;
        hit_dir = dir_ok & ~wp_err;
        hit_bd  = bd_ok & ~dir_ok & ~wp_err;
    end
endmodule

// File: rtl/fwin_delay.sv
`timescale 1ns/1ps
// Fixed-length pulse delay line of N register stages (N >= 1).
module fwin_delay #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (N == 1) begin : g_one
            logic st_q;
            // Single stage.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= 1'b0;
                else        st_q <= d;
            end
            assign q = st_q;
        end else begin : g_many
            logic [N-1:0] st_q;
            // Shift the pulse one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= {st_q[N-2:0], d};
            end
            assign q = st_q[N-1];
        end
    endgenerate
endmodule

// File: rtl/flash_window_decoder.sv
`timescale 1ns/1ps
// Flash window decoder top: configuration register, window match,
// registered select and latency-matched ready.
// Assumes accesses are single-cycle requests on acc_valid.
module flash_window_decoder
    import flash_win_pkg::*;
#(
    parameter int          BASE_LAT  = 1,
    parameter logic [31:0] BD_OFFSET = 32'h0400_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_cfg_en,
    input  logic [2:0]         boot_mode,
    input  logic [1:0]         boot_sel,
    input  logic               flash_secured,
    input  logic               reg_wr_en,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [12:0]        periph_page,
    input  logic               acc_valid,
    input  logic [12:0]        acc_page,
    input  logic               acc_write,
    input  logic               acc_super,
    input  logic               acc_code,
    input  logic               acc_core,
    output logic               sel_none,
    output logic               sel_direct,
    output logic               sel_backdoor,
    output logic               acc_err,
    output logic               acc_ready
);
    localparam logic [FW_PG_W-1:0] BD_PG     = BD_OFFSET[FW_AW-1:FW_WIN_LOG2];
    localparam int                 FAST_LEN  = BASE_LAT + 1;
    localparam int                 SLOW_LEN  = BASE_LAT + 3;

    fw_dec_t dec;
    logic    hit_dir, hit_bd, wp_err;
    logic    dir_q, bd_q, err_q;
    logic    go_fast, go_slow, rdy_fast, rdy_slow;

    fwin_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_cfg_en  (boot_cfg_en),
        .boot_mode    (boot_mode),
        .boot_sel     (boot_sel),
        .flash_secured(flash_secured),
        .wr_en        (reg_wr_en),
        .wdata        (reg_wdata),
        .dec          (dec),
        .rdata        (reg_rdata)
    );

    fwin_match #(.BD_PG(BD_PG)) u_match (
        .dec        (dec),
        .acc_valid  (acc_valid),
        .acc_page   (acc_page),
        .periph_page(periph_page),
        .acc_write  (acc_write),
        .acc_super  (acc_super),
        .acc_code   (acc_code),
        .acc_core   (acc_core),
        .hit_dir    (hit_dir),
        .hit_bd     (hit_bd),
        .wp_err     (wp_err)
    );

    // Register the decision so selects are one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            bd_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            dir_q <= hit_dir;
            bd_q  <= hit_bd;
            err_q <= wp_err;
        end
    end

    // Alias reads take the long path; everything else the short one.
    always_comb begin
        go_fast = hit_dir | (hit_bd & acc_write);
        go_slow = hit_bd & ~acc_write;
    end

    fwin_delay #(.N(FAST_LEN)) u_fast (
        .clk(clk), .rst_n(rst_n), .d(go_fast), .q(rdy_fast)
    );

    fwin_delay #(.N(SLOW_LEN)) u_slow (
        .clk(clk), .rst_n(rst_n), .d(go_slow), .q(rdy_slow)
    );

    assign sel_direct   = dir_q;
    assign sel_backdoor = bd_q;
    assign sel_none     = ~dir_q & ~bd_q;
    assign acc_err      = err_q;
    assign acc_ready    = rdy_fast | rdy_slow;
endmodule

// File: rtl/fwin_checker.sv
`timescale 1ns/1ps
// Property checker for the flash window decoder, bound to the top.
module fwin_checker (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_write,
    input logic acc_core,
    input logic reg_v,
    input logic reg_wp,
    input logic sel_none,
    input logic sel_direct,
    input logic sel_backdoor,
    input logic acc_err
);
    // R9: select outputs one-hot
    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_none, sel_direct, sel_backdoor}) == 1);

    // R9: no access presented means no select next cycle
    a_r9_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> sel_none);

    // R6: direct select requires enable and a core master
    a_r6_direct_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sel_direct |-> $past(reg_v && acc_core));

    // R8: error only from a protected write, and never with a select
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($past(acc_valid && acc_write && reg_wp) && sel_none));
endmodule

bind flash_window_decoder fwin_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_core    (acc_core),
    .reg_v       (reg_rdata[0]),
    .reg_wp      (reg_rdata[8]),
    .sel_none    (sel_none),
    .sel_direct  (sel_direct),
    .sel_backdoor(sel_backdoor),
    .acc_err     (acc_err)
);

// File: tb/flash_window_decoder_test.sv
`timescale 1ns/1ps
// Self-checking bench: reset sweep, directed corners, seeded random accesses.
module flash_window_decoder_test;
    localparam int          LAT   = 1;
    localparam logic [31:0] WMASK = 32'hFFF8_017D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_cfg_en = 1'b1;
    logic [2:0]  boot_mode = 3'b110;
    logic [1:0]  boot_sel = 2'b00;
    logic        flash_secured = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] periph_page = 13'h800;
    logic        acc_valid = 1'b0;
    logic [12:0] acc_page = '0;
    logic        acc_write = 1'b0;
    logic        acc_super = 1'b0;
    logic        acc_code = 1'b0;
    logic        acc_core = 1'b0;
    logic        sel_none, sel_direct, sel_backdoor, acc_err, acc_ready;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_reg;
    bit          done = 0;

    always #2 clk = ~clk;   // 250 MHz

    flash_window_decoder #(.BASE_LAT(LAT)) uut (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Expected outcome {direct, alias, error} from the requirements.
    function automatic logic [2:0] model(input logic [12:0] pg, input logic [12:0] pb,
                                         input logic w, input logic s, input logic c,
                                         input logic core);
        logic dc, bc;
        dc = core & exp_reg[0] & (pg == exp_reg[31:19]) & ~exp_reg[2 + {s, c}];
        bc = (pg == pb + 13'h080);
        if ((dc | bc) & w & exp_reg[8]) return 3'b001;
        if (dc) return 3'b100;
        if (bc) return 3'b010;
        return 3'b000;
    endfunction

    function automatic logic exp_valid(input logic en, input logic [2:0] m,
                                       input logic [1:0] sl, input logic sec);
        return sec | (en & m == 3'b110) | (en & m == 3'b111 & sl == 2'b00);
    endfunction

    task automatic do_reset(input logic en, input logic [2:0] m, input logic [1:0] sl,
                            input logic sec);
        @(negedge clk);
        boot_cfg_en = en; boot_mode = m; boot_sel = sl; flash_secured = sec;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_reg = 32'h0000_0100 | {31'b0, exp_valid(en, m, sl, sec)};
        // R3 fields plus R4/R5 enable value
        check(sec ? "R5 secured reset" : "R3/R4 reset value", reg_rdata, exp_reg);
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        exp_reg = d & WMASK;
        check("R2 register readback", reg_rdata, exp_reg);
    endtask

    task automatic do_acc(input logic [12:0] pg, input logic [12:0] pb, input logic w,
                          input logic s, input logic c, input logic core);
        logic [2:0] e;
        int         off;
        int         bad;
        e = model(pg, pb, w, s, c, core);
        @(negedge clk);
        acc_valid = 1'b1; acc_page = pg; periph_page = pb;
        acc_write = w; acc_super = s; acc_code = c; acc_core = core;
        @(negedge clk);
        acc_valid = 1'b0;
        if (e[2])      check("R1 direct select", {sel_none, sel_direct, sel_backdoor, acc_err}, 4'b0100);
        else if (e[1]) check("R7 alias select", {sel_none, sel_direct, sel_backdoor, acc_err}, 4'b0010);
        else if (e[0]) check("R8 protected write", {sel_none, sel_direct, sel_backdoor, acc_err}, 4'b1001);
        else           check("R6 R9 no select", {sel_none, sel_direct, sel_backdoor, acc_err}, 4'b1000);
        off = -1;
        if (e[2] | (e[1] & w)) off = LAT;
        else if (e[1])         off = LAT + 2;
        bad = -1;
        for (int j = 0; j < LAT + 5; j++) begin
            if (j > 0) @(negedge clk);
            if (bad < 0 && acc_ready !== (j == off)) bad = j;
        end
        // R10 ready timing: bad holds the first mismatching offset
        check("R10 ready timing", bad, -1);
    endtask

    initial begin
        logic [31:0] d;
        logic [12:0] pg, pb;
        void'($urandom(32'd20240611));
        // Reset sweep over all pin combinations (R4), then secured parts (R5).
        for (int i = 0; i < 64; i++)
            do_reset(i[0], i[3:1], i[5:4], 1'b0);
        do_reset(1'b0, 3'b000, 2'b11, 1'b1);
        do_reset(1'b1, 3'b111, 2'b01, 1'b1);
        // Default boot: enabled, page 0, protected.
        do_reset(1'b1, 3'b110, 2'b00, 1'b0);
        do_acc(13'h000, 13'h800, 1'b0, 1'b1, 1'b1, 1'b1);   // R1 direct read at 0x0
        do_acc(13'h000, 13'h800, 1'b1, 1'b1, 1'b0, 1'b1);   // R8 protected write
        do_acc(13'h880, 13'h800, 1'b0, 1'b0, 1'b0, 1'b0);   // R7 alias at 0x4400_0000
        do_acc(13'h000, 13'h800, 1'b0, 1'b1, 1'b1, 1'b0);   // R6 non-core misses direct
        // R2: reserved bits ignored.
        reg_write(32'hFFFF_FFFF);
        reg_write(32'h0000_0001);                            // unprotected, no masks
        do_acc(13'h880, 13'h800, 1'b1, 1'b0, 1'b0, 1'b0);   // R7 alias write, short latency
        // R6 each mask bit against its own access type.
        for (int k = 0; k < 4; k++) begin
            reg_write(32'h0000_0001 | (32'h4 << k));
            do_acc(13'h000, 13'h800, 1'b0, k[1], k[0], 1'b1);
            do_acc(13'h000, 13'h800, 1'b0, ~k[1], k[0], 1'b1);
        end
        // R7 priority: direct page placed on the alias page.
        reg_write(32'h4400_0001);
        do_acc(13'h880, 13'h800, 1'b0, 1'b0, 1'b0, 1'b1);
        do_acc(13'h880, 13'h800, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_write(32'h4400_0000);                            // R6 disabled direct falls to alias
        do_acc(13'h880, 13'h800, 1'b0, 1'b1, 1'b1, 1'b1);
        // Seeded random mix.
        for (int n = 0; n < 500; n++) begin
            if ($urandom % 8 == 0) begin
                d = $urandom;
                case ($urandom % 3)
                    0: d[31:19] = 13'h000;
                    1: d[31:19] = 13'h880;
                    default: ;
                endcase
                d[0] = ($urandom % 5 != 0);
                d[8] = ($urandom % 4 == 0);
                if ($urandom % 3 != 0) d[5:2] = 4'b0;
                reg_write(d);
            end
            pb = ($urandom % 2 == 0) ? 13'h800 : 13'($urandom);
            case ($urandom % 4)
                0, 3: pg = exp_reg[31:19];
                1:    pg = pb + 13'h080;
                default: pg = 13'($urandom);
            endcase
            do_acc(pg, pb, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 != 0));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule